// File: doc/BRIEF.md
# Overlapped Two-ALU Latched Datapath

This block is a small datapath with two ALUs and an eight-entry register file. A stream of control-step words drives it. Each word gives each ALU an opcode, two source register indices and a destination index. Every ALU has a latch on its operands and a latch on its result, so each operation takes three clock edges:

- On the first edge the operands are captured from the register file through four operand buses, two per ALU.
- On the second edge the ALU result is captured in its output latch.
- On the third edge the result is written to the register file.

Consecutive control steps overlap completely. In any cycle, one step is being read, the step before it is executing and the step before that is writing back. The register file has four read paths and two write paths. A source that names a register still in flight is served by forwarding, so a step always sees the architectural result of every earlier step. A combinational debug port reads any register.

Top module: `dp_pipe`

## Requirements
- R1: After reset, the pipeline holds no operation, and register k (0 to 7) holds `k*16'h1111` truncated to 16 bits.
- R2: The 3-bit opcodes are: 0 = idle, 1 = a+b, 2 = a-b (modulo 2^16), 3 = a AND b, 4 = a OR b, 5 = pass a. Codes 6 and 7 behave as idle. An idle slot writes no register.
- R3: A word sampled on edge n changes the register file on edge n+2. After edge n+1 the debug port still shows the old value.
- R4: A new control word can be accepted on every cycle. Every result of a back-to-back stream lands in the register file in order.
- R5: A source that names the destination of one of the two preceding steps receives that step's result, not the stale register value.
- R6: Both ALUs of one step read the register values from before that step, even when the other ALU of the same step writes the same register.
- R7: When both ALUs of one step write the same register, the ALU2 result is kept. A following step that reads that register also receives the ALU2 result.
- R8: When `cw_valid` is low, both slots are idle and no register changes, whatever the opcode and index fields hold.
- R9: `dbg_data` shows the current contents of the register selected by `dbg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Control word present this cycle |
| a1_op | input | 3 | ALU1 opcode |
| a1_src_a | input | 3 | ALU1 first source register |
| a1_src_b | input | 3 | ALU1 second source register |
| a1_dst | input | 3 | ALU1 destination register |
| a2_op | input | 3 | ALU2 opcode |
| a2_src_a | input | 3 | ALU2 first source register |
| a2_src_b | input | 3 | ALU2 second source register |
| a2_dst | input | 3 | ALU2 destination register |
| dbg_addr | input | 3 | Debug read register index |
| dbg_data | output | 16 | Debug read data |

## Verification
The assertions rely on two assumptions about the inputs:

- `rst_n` is held low through the first clock edge.
- The control inputs are stable around each rising edge.

The latency check also relies on an internal saturating counter of edges since reset, so that it never looks at words sampled during reset. The bench changes inputs only on falling edges and keeps `cw_valid` low throughout reset. It drives the stated schedule back to back, then directed hazard and opcode cases, then a stream of words with random opcodes and register indices. A sequential model predicts the register contents for each cycle.

// File: rtl/dp_pipe.sv
module dp_pipe #(
  parameter int DW = 16,
  parameter int NREG = 8,
  parameter int INIT_STEP = 'h1111,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_valid,
  input  logic [2:0]    a1_op,
  input  logic [AW-1:0] a1_src_a,
  input  logic [AW-1:0] a1_src_b,
  input  logic [AW-1:0] a1_dst,
  input  logic [2:0]    a2_op,
  input  logic [AW-1:0] a2_src_a,
  input  logic [AW-1:0] a2_src_b,
  input  logic [AW-1:0] a2_dst,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_SUB  = 3'd2;
  localparam logic [2:0] OP_AND  = 3'd3;
  localparam logic [2:0] OP_OR   = 3'd4;
  localparam logic [2:0] OP_PASS = 3'd5;

  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR) || (op == OP_PASS);
  endfunction

  function automatic logic [DW-1:0] alu_f(input logic [2:0] op,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_PASS: return a;
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] rf [NREG];

  logic [2:0]    s_op  [2];
  logic [AW-1:0] s_src [4];
  logic [AW-1:0] s_dst [2];

  assign s_op[0]  = a1_op;
  assign s_op[1]  = a2_op;
  assign s_src[0] = a1_src_a;
  assign s_src[1] = a1_src_b;
  assign s_src[2] = a2_src_a;
  assign s_src[3] = a2_src_b;
  assign s_dst[0] = a1_dst;
  assign s_dst[1] = a2_dst;

  logic [2:0]    x_op  [2];
  logic [DW-1:0] x_a   [2];
  logic [DW-1:0] x_b   [2];
  logic [AW-1:0] x_dst [2];
  logic [DW-1:0] x_res [2];
  logic          x_we  [2];
  logic [DW-1:0] w_res [2];
  logic [AW-1:0] w_dst [2];
  logic          w_we  [2];
  logic [DW-1:0] bus   [4];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      x_we[i]  = op_writes(x_op[i]);
      x_res[i] = alu_f(x_op[i], x_a[i], x_b[i]);
    end
  end

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      bus[j] = rf[s_src[j]];
      for (int i = 0; i < 2; i++)
        if (w_we[i] && w_dst[i] == s_src[j]) bus[j] = w_res[i];
      for (int i = 0; i < 2; i++)
        if (x_we[i] && x_dst[i] == s_src[j]) bus[j] = x_res[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) rf[k] <= DW'(k * INIT_STEP);
      for (int i = 0; i < 2; i++) begin
        x_op[i]  <= OP_NOP;
        x_a[i]   <= '0;
        x_b[i]   <= '0;
        x_dst[i] <= '0;
        w_res[i] <= '0;
        w_dst[i] <= '0;
        w_we[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        x_op[i]  <= cw_valid ? s_op[i] : OP_NOP;
        x_a[i]   <= bus[2*i];
        x_b[i]   <= bus[2*i+1];
        x_dst[i] <= s_dst[i];
        w_res[i] <= x_res[i];
        w_dst[i] <= x_dst[i];
        w_we[i]  <= x_we[i];
      end
      if (w_we[0]) rf[w_dst[0]] <= w_res[0];
      if (w_we[1]) rf[w_dst[1]] <= w_res[1];
    end
  end

  assign dbg_data = rf[dbg_addr];

  logic [NREG*DW-1:0] rf_flat;
  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign rf_flat[g*DW +: DW] = rf[g];
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(cw_valid, 2) && op_writes($past(a1_op, 2)))
      |-> (w_we[0] && w_dst[0] == $past(a1_dst, 2)));

  // R8
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_valid |=> (x_op[0] == OP_NOP && x_op[1] == OP_NOP));

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_we[0] && !w_we[1]) |=> $stable(rf_flat));

  // R4
  wb_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_we[0] && !(w_we[1] && w_dst[1] == w_dst[0]))
      |=> rf[$past(w_dst[0])] == $past(w_res[0]));

  // R7
  tie_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_we[0] && w_we[1] && w_dst[0] == w_dst[1])
      |=> rf[$past(w_dst[1])] == $past(w_res[1]));

endmodule

// File: tb/dp_pipe_tb.sv
module dp_pipe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cw_valid = 1'b0;
  logic [2:0] a1_op = '0, a2_op = '0;
  logic [2:0] a1_src_a = '0, a1_src_b = '0, a1_dst = '0;
  logic [2:0] a2_src_a = '0, a2_src_b = '0, a2_dst = '0;
  logic [2:0] dbg_addr = '0;
  logic [15:0] dbg_data;

  always #10 clk = ~clk;

  dp_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid),
    .a1_op(a1_op), .a1_src_a(a1_src_a), .a1_src_b(a1_src_b), .a1_dst(a1_dst),
    .a2_op(a2_op), .a2_src_a(a2_src_a), .a2_src_b(a2_src_b), .a2_dst(a2_dst),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [15:0] ref_rf [8];
  int due_q [$];
  logic [127:0] exp_q [$];
  string tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                     input string tag, input int r);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s reg r%0d actual=%h expected=%h", tag, r, act, exp);
    end
  endtask

  function automatic logic [16:0] ref_alu(input logic [2:0] op,
                                          input logic [15:0] a,
                                          input logic [15:0] b);
    case (op)
      3'd1: return {1'b1, a + b};
      3'd2: return {1'b1, a - b};
      3'd3: return {1'b1, a & b};
      3'd4: return {1'b1, a | b};
      3'd5: return {1'b1, a};
      default: return {1'b0, 16'h0};
    endcase
  endfunction

  task automatic step(input bit v,
                      input logic [2:0] o1, input int s1a, input int s1b, input int d1,
                      input logic [2:0] o2, input int s2a, input int s2b, input int d2,
                      input string tag);
    logic [16:0] r1, r2;
    logic [127:0] snap;
    @(negedge clk);
    cw_valid = v;
    a1_op = o1; a1_src_a = 3'(s1a); a1_src_b = 3'(s1b); a1_dst = 3'(d1);
    a2_op = o2; a2_src_a = 3'(s2a); a2_src_b = 3'(s2b); a2_dst = 3'(d2);
    if (v) begin
      r1 = ref_alu(o1, ref_rf[s1a], ref_rf[s1b]);
      r2 = ref_alu(o2, ref_rf[s2a], ref_rf[s2b]);
      if (r1[16]) ref_rf[d1] = r1[15:0];
      if (r2[16]) ref_rf[d2] = r2[15:0];
    end
    for (int r = 0; r < 8; r++) snap[r*16 +: 16] = ref_rf[r];
    due_q.push_back(cyc + 3);
    exp_q.push_back(snap);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 3'd6, 7, 7, 7, 3'd1, 1, 2, 3, tag);
  endtask

  // scoreboard monitor: checks every register in the cycle its item falls due
  initial begin
    forever begin
      @(negedge clk);
      while (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        void'(due_q.pop_front());
        for (int r = 0; r < 8; r++) begin
          dbg_addr = 3'(r);
          #1;
          chk(dbg_data, e[r*16 +: 16], t, r);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) ref_rf[k] = 16'(k * 16'h1111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents, read through the combinational debug port (R9)
    for (int r = 0; r < 8; r++) begin
      dbg_addr = 3'(r);
      #1;
      chk(dbg_data, 16'(r * 16'h1111), "R1 R9", r);
    end

    // stated schedule, back to back: R4 overlap, R5 forwarding, R6 same-step reads
    step(1'b1, 3'd1, 1, 2, 3, 3'd2, 3, 4, 1, "R4 R6");
    step(1'b1, 3'd1, 5, 6, 1, 3'd1, 2, 5, 6, "R4 R5");
    step(1'b1, 3'd1, 1, 6, 3, 3'd0, 0, 0, 0, "R4 R5");
    idle(4, "R8");

    // opcode coverage, SUB wraps below zero (R2)
    step(1'b1, 3'd2, 0, 7, 2, 3'd3, 7, 5, 4, "R2");
    step(1'b1, 3'd4, 2, 4, 0, 3'd5, 6, 0, 5, "R2");
    step(1'b1, 3'd6, 1, 2, 1, 3'd7, 3, 4, 2, "R2");
    step(1'b1, 3'd0, 1, 2, 3, 3'd1, 1, 1, 7, "R2");
    idle(3, "R3");

    // both ALUs write r4; ALU2 wins, the next step reads ALU2's value (R7)
    step(1'b1, 3'd1, 1, 1, 4, 3'd2, 3, 1, 4, "R7");
    step(1'b1, 3'd5, 4, 0, 6, 3'd1, 4, 4, 2, "R7");
    idle(3, "R7");

    // forwarding from two steps back across an unrelated step (R5)
    step(1'b1, 3'd1, 5, 6, 2, 3'd0, 0, 0, 0, "R5");
    step(1'b1, 3'd3, 0, 1, 7, 3'd4, 3, 3, 0, "R5");
    step(1'b1, 3'd2, 2, 7, 3, 3'd1, 2, 2, 1, "R5");
    idle(3, "R5");

    // same-step read of a register the other ALU writes (R6)
    step(1'b1, 3'd1, 1, 1, 5, 3'd5, 5, 0, 6, "R6");
    idle(3, "R6");

    // invalid word with writing opcodes changes nothing (R8)
    step(1'b0, 3'd1, 1, 2, 0, 3'd5, 3, 3, 1, "R8");
    step(1'b0, 3'd2, 4, 4, 2, 3'd4, 5, 6, 3, "R8");
    idle(3, "R8");

    // random back-to-back stream (R4)
    for (int n = 0; n < 60; n++)
      step(1'b1, 3'($urandom_range(7)), int'($urandom_range(7)), int'($urandom_range(7)),
           int'($urandom_range(7)), 3'($urandom_range(7)), int'($urandom_range(7)),
           int'($urandom_range(7)), int'($urandom_range(7)), "R4");
    idle(4, "R4");

    while (due_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule